// File: doc/BRIEF.md
# DMA Transfer-End Status and Interrupt Register

This block keeps, for each channel of an eight-channel DMA engine, a sticky record of the end of a transfer. Every channel has a single-cycle end pulse input. A pulse sets a detect flag and a matching interrupt-request flag for that channel. The request flag, gated by a per-channel enable, drives a per-channel interrupt line. All these lines are also ORed into one combined interrupt.

Software reaches the flags through a small 32-bit register port. The eight flags sit in the top byte in reversed channel order: channel 0 is the most significant bit. The lower 24 bits are reserved and read as zero. Writing a one to a flag clears both the detect flag and the request flag of that channel. Writing a zero, reading, or writing to reserved bits changes nothing. A write never sets a flag. The port has no flow control: every access completes in its own cycle, and read data comes out of a register one cycle later.

Top module: `dma_end_status`

## Requirements
- R1: An end pulse on channel c sets that channel's detect flag. From the next read onward the flag shows in read-data bit 31-c, so channel 0 is bit 31 and channel 7 is bit 24.
- R2: Read-data bits 23 to 0 are always zero. Writing ones to those bits changes no flag.
- R3: A read access leaves every flag unchanged.
- R4: A write with data bit 31-c at one clears channel c's detect flag. A zero in that bit leaves the flag as it was.
- R5: A write never sets a flag that is clear.
- R6: Clearing channel c's detect flag by a write also clears its interrupt-request flag, so `ch_irq[c]` goes low in the cycle after the write.
- R7: When an end pulse on channel c and a clearing write to bit 31-c happen in the same cycle, the flag ends up set.
- R8: `ch_irq[c]` is channel c's request flag ANDed with `irq_en[c]`. `irq_any` is the OR of all bits of `ch_irq`.
- R9: Read data is registered. An access with `bus_sel`=1 and `bus_we`=0 returns, in the next cycle, the flags as they stood before that access's clock edge. In every cycle that follows a non-read, `bus_rdata` is zero.
- R10: After reset every flag is clear, `bus_rdata` is zero and no interrupt output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| end_pulse | input | 8 | Per-channel transfer-end pulse, one cycle wide, bit c = channel c |
| irq_en | input | 8 | Per-channel interrupt enable |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write (clear by ones), 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch_irq | output | 8 | Per-channel interrupt |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
The hardware set path and the software clear path can hit the same flag in the same clock. The bench provokes this by raising a channel's end pulse in the same cycle as a write that carries a one in that channel's bit. It then expects the flag to survive in the following read. A read in the same cycle as a pulse is also provoked; it must return the value from before the pulse, and the pulse must show on the next read. A behavioural model, compared at every falling edge, judges all other overlaps of pulses, writes, reads and enable changes.

// File: rtl/dmaes_pkg.sv
package dmaes_pkg;
  localparam int unsigned CH_COUNT  = 8;
  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e decode_acc(input logic sel, input logic we);
    if (!sel)    return ACC_NONE;
    else if (we) return ACC_WRITE;
    else         return ACC_READ;
  endfunction
endpackage

// File: rtl/dmaes_flag_cell.sv
module dmaes_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic det_o,
  output logic req_o
);
  logic det_q, req_q;

  // set has priority over clear so that no end event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (set_i) begin
        det_q <= 1'b1;
        req_q <= 1'b1;
      end else if (clr_i) begin
        det_q <= 1'b0;
        req_q <= 1'b0;
      end
    end
  end

  assign det_o = det_q;
  assign req_o = req_q;
endmodule

// File: rtl/dmaes_bus_port.sv
module dmaes_bus_port
  import dmaes_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_COUNT,
  parameter int unsigned DW     = WORD_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  input  logic [NUM_CH-1:0] flags,
  output logic [NUM_CH-1:0] clr,
  output logic [DW-1:0]     rdata
);
  localparam int unsigned TOP = DW - 1;

  acc_kind_e     kind;
  logic [DW-1:0] image;

  assign kind = decode_acc(sel, we);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_map
    assign clr[c]         = (kind == ACC_WRITE) && wdata[TOP-c];
    assign image[TOP-c]   = flags[c];
  end
  assign image[DW-NUM_CH-1:0] = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rdata <= '0;
    else if (kind == ACC_READ) rdata <= image;
    else                       rdata <= '0;
  end
endmodule

// File: rtl/dmaes_irq_merge.sv
module dmaes_irq_merge #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] en,
  output logic [NUM_CH-1:0] ch_irq,
  output logic              any_irq
);
  assign ch_irq  = req & en;
  assign any_irq = |ch_irq;
endmodule

// File: rtl/dma_end_status.sv
module dma_end_status
  import dmaes_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_COUNT,
  parameter int unsigned DW     = WORD_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] end_pulse,
  input  logic [NUM_CH-1:0] irq_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] ch_irq,
  output logic              irq_any
);
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] det_q;
  logic [NUM_CH-1:0] req_q;

  dmaes_bus_port #(.NUM_CH(NUM_CH), .DW(DW)) u_port (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (bus_sel),
    .we    (bus_we),
    .wdata (bus_wdata),
    .flags (det_q),
    .clr   (clr_vec),
    .rdata (bus_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dmaes_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (end_pulse[c]),
      .clr_i (clr_vec[c]),
      .det_o (det_q[c]),
      .req_o (req_q[c])
    );
  end

  dmaes_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
    .req     (req_q),
    .en      (irq_en),
    .ch_irq  (ch_irq),
    .any_irq (irq_any)
  );
endmodule

// File: rtl/dmaes_checker.sv
module dmaes_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] end_pulse,
  input logic [NUM_CH-1:0] irq_en,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [NUM_CH-1:0] ch_irq,
  input logic [NUM_CH-1:0] det_q,
  input logic [NUM_CH-1:0] req_q
);
  logic [NUM_CH-1:0] wr_mask;
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) wr_mask[c] = bus_wdata[DW-1-c];
  end

  // R1
  a_r1_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|end_pulse) |=> ((det_q & $past(end_pulse)) == $past(end_pulse)));

  // R2
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-NUM_CH-1:0] == '0);

  // R3
  a_r3_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> ((det_q & $past(det_q)) == $past(det_q)));

  // R4 and R6: cleared channels drop both flags unless re-pulsed
  a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |=> ((det_q & $past(wr_mask) & ~$past(end_pulse)) == '0));
  a_r6_clear_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |=> ((req_q & $past(wr_mask) & ~$past(end_pulse)) == '0));

  // R5
  a_r5_write_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |=> ((det_q & ~$past(det_q) & ~$past(end_pulse)) == '0));

  // R7
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && (|(end_pulse & wr_mask))) |=>
      ((det_q & $past(end_pulse)) == $past(end_pulse)));

  // R8
  a_r8_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_irq & ~irq_en) == '0);
endmodule

bind dma_end_status dmaes_checker #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .end_pulse (end_pulse),
  .irq_en    (irq_en),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .ch_irq    (ch_irq),
  .det_q     (det_q),
  .req_q     (req_q)
);

// File: tb/dma_end_status_tb.sv
module dma_end_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  end_pulse = '0;
  logic [7:0]  irq_en = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  ch_irq;
  logic        irq_any;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_end_status u_dut (
    .clk(clk), .rst_n(rst_n), .end_pulse(end_pulse), .irq_en(irq_en),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ch_irq(ch_irq), .irq_any(irq_any)
  );

  // behavioural reference model
  bit [7:0]  m_det, m_req;
  bit [31:0] m_rd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_det <= '0; m_req <= '0; m_rd <= '0;
    end else begin
      bit [31:0] img;
      bit [7:0] nd, nr;
      img = '0;
      nd = m_det; nr = m_req;
      for (int c = 0; c < 8; c++) begin
        img[31-c] = m_det[c];
        if (bus_sel && bus_we && bus_wdata[31-c]) begin nd[c] = 0; nr[c] = 0; end
        if (end_pulse[c]) begin nd[c] = 1; nr[c] = 1; end
      end
      m_rd  <= (bus_sel && !bus_we) ? img : 32'h0;
      m_det <= nd;
      m_req <= nr;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R9 model rdata", bus_rdata, m_rd);
    chk("R8 model ch_irq", {24'h0, ch_irq}, {24'h0, m_req & irq_en});
    chk("R8 model irq_any", {31'h0, irq_any}, {31'h0, |(m_req & irq_en)});
  end

  task automatic cyc(input logic [7:0] p, input logic s, input logic w, input logic [31:0] d);
    @(negedge clk); #1;
    end_pulse = p; bus_sel = s; bus_we = w; bus_wdata = d;
  endtask

  task automatic rd(output logic [31:0] v);
    cyc(8'h00, 1'b1, 1'b0, 32'h0);
    cyc(8'h00, 1'b0, 1'b0, 32'h0);
    v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    rd(v);
    chk("R10 flags after reset", v, 32'h0);
    chk("R10 irq after reset", {23'h0, irq_any, ch_irq}, 32'h0);
    irq_en = 8'hFF;
    // R1 channel 0 maps to bit 31
    cyc(8'h01, 1'b0, 1'b0, 32'h0);
    rd(v);
    chk("R1 ch0 at bit31", v, 32'h8000_0000);
    chk("R8 ch_irq ch0", {24'h0, ch_irq}, 32'h01);
    // R3 read does not clear
    rd(v);
    chk("R3 flag kept after read", v, 32'h8000_0000);
    // R1 channel 7 maps to bit 24
    cyc(8'h80, 1'b0, 1'b0, 32'h0);
    rd(v);
    chk("R1 ch7 at bit24", v, 32'h8100_0000);
    // R2 reserved writes ignored
    cyc(8'h00, 1'b1, 1'b1, 32'h00FF_FFFF);
    rd(v);
    chk("R2 reserved write no effect", v, 32'h8100_0000);
    // R5 ones to clear flags do not set them
    cyc(8'h00, 1'b1, 1'b1, 32'h7E00_0000);
    rd(v);
    chk("R5 write never sets", v, 32'h8100_0000);
    // R4 clear ch0 with zeros elsewhere
    cyc(8'h00, 1'b1, 1'b1, 32'h8000_0000);
    cyc(8'h00, 1'b0, 1'b0, 32'h0);
    chk("R6 irq drops with clear", {24'h0, ch_irq}, 32'h80);
    rd(v);
    chk("R4 ch0 cleared ch7 kept", v, 32'h0100_0000);
    // R7 set and clear on ch3 in same cycle
    cyc(8'h08, 1'b1, 1'b1, 32'h1000_0000);
    rd(v);
    chk("R7 set wins over clear", v, 32'h1100_0000);
    // R8 enable gating
    cyc(8'h00, 1'b0, 1'b0, 32'h0); irq_en = 8'h08;
    cyc(8'h00, 1'b0, 1'b0, 32'h0);
    chk("R8 only ch3 enabled", {23'h0, irq_any, ch_irq}, 32'h108);
    irq_en = 8'h00;
    cyc(8'h00, 1'b0, 1'b0, 32'h0);
    chk("R8 all disabled", {23'h0, irq_any, ch_irq}, 32'h000);
    irq_en = 8'hFF;
    // R9 read with same-cycle pulse returns old value
    cyc(8'h20, 1'b1, 1'b0, 32'h0);
    cyc(8'h00, 1'b0, 1'b0, 32'h0);
    chk("R9 read returns pre-pulse", bus_rdata, 32'h1100_0000);
    cyc(8'h00, 1'b0, 1'b0, 32'h0);
    chk("R9 rdata zero after non-read", bus_rdata, 32'h0);
    rd(v);
    chk("R9 pulse visible next read", v, 32'h1500_0000);
    // clear everything
    cyc(8'h00, 1'b1, 1'b1, 32'hFFFF_FFFF);
    rd(v);
    chk("R4 clear all", v, 32'h0);
    chk("R6 no irq after clear all", {23'h0, irq_any, ch_irq}, 32'h0);
    repeat (2) cyc(8'h00, 1'b0, 1'b0, 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule